// File: doc/BRIEF.md
# Push-button Reset Classifier and Board Reset Fan-out

This block turns one debounced, active-low reset button into two kinds of processor reset. It also spreads a board-level power-on condition to every peripheral reset line. The time the button is held is measured in ticks of a free-running prescaler. The hold is classified when the button is let go:

- A hold below the short threshold is treated as noise.
- A hold of at least the short threshold (about one second by default) fires a fixed-length system (soft) reset pulse.
- A hold of at least the long threshold (about three seconds by default) fires a processor power-on reset pulse instead.

Both button actions are taken only if the processor reports that it is ready to be reset when the button is released.

The peripheral resets are level functions. The PCIe reset, the two USB resets (PHY and hub) and the Ethernet reset are each held while power is not ready or while their own processor request bit is set. The PLL reset, the I2C mux reset, the fan enable and the display enable depend on the power-ready flag alone. Every level input passes a two-stage synchronizer, and every output is registered. All outputs are driven to their asserted (low) level while the controller itself is in reset.

Top module: `rst_dist_ctrl`

## Requirements
- R1: While `rst` is high, every output (all `*_rst_n` lines, `fan_en`, `dp_en`) is 0 one clock after the reset edge.
- R2: A button hold shorter than SHORT_MS produces no low level on `ps_srst_n` or `ps_por_n`.
- R3: A hold of at least SHORT_MS but shorter than LONG_MS drives `ps_srst_n` low for exactly PULSE_CYCLES consecutive cycles after release, and `ps_por_n` stays high.
- R4: A hold of at least LONG_MS drives `ps_por_n` low for exactly PULSE_CYCLES cycles after release, and `ps_srst_n` stays high.
- R5: When `rst_ready` is 0 at release, a short or long hold produces no pulse on either processor reset.
- R6: `pcie_rst_n` is 0 when `pwr_ready` is 0 or `sw_rst_req[0]` is 1, and 1 otherwise.
- R7: `usb_phy_rst_n` and `usb_hub_rst_n` are both 0 when `pwr_ready` is 0 or `sw_rst_req[1]` is 1, and 1 otherwise.
- R8: `eth_rst_n` is 0 when `pwr_ready` is 0 or `sw_rst_req[2]` is 1, and 1 otherwise.
- R9: `pll_rst_n`, `i2c_rst_n`, `fan_en` and `dp_en` equal the synchronized `pwr_ready` and are not affected by `sw_rst_req`.
- R10: A change on `pwr_ready` or `sw_rst_req` reaches the level outputs exactly three clock edges later (two synchronizer stages plus the output register).
- R11: A hold far beyond LONG_MS yields one power-on reset pulse only, issued after release. No pulse appears while the button is still held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high controller reset |
| btn_n | input | 1 | Debounced reset button, 0 = pressed |
| pwr_ready | input | 1 | Board power ready, 1 = rails good |
| rst_ready | input | 1 | Processor accepts button resets when 1 |
| sw_rst_req | input | 3 | Processor reset requests: bit 0 PCIe, bit 1 USB, bit 2 Ethernet (1 = hold in reset) |
| ps_srst_n | output | 1 | Processor system reset, active low |
| ps_por_n | output | 1 | Processor power-on reset, active low |
| pcie_rst_n | output | 1 | PCIe reset, active low |
| usb_phy_rst_n | output | 1 | USB PHY reset, active low |
| usb_hub_rst_n | output | 1 | USB hub reset, active low |
| eth_rst_n | output | 1 | Ethernet PHY reset, active low |
| pll_rst_n | output | 1 | Module PLL reset, active low |
| i2c_rst_n | output | 1 | I2C mux reset, active low |
| fan_en | output | 1 | Fan enable, 1 = on |
| dp_en | output | 1 | Display output enable, 1 = on |

## Verification
The pulse-width assertions assume that no second qualifying button release arrives while a processor reset pulse is still running. The stimulus therefore waits far longer than PULSE_CYCLES between holds. The latency assertions assume the level inputs come from a single clock domain, so the bench changes them only on the falling clock edge. The bench keeps `rst_ready` constant for the whole of each hold. Each hold is also chosen several ticks away from both thresholds, so that the one-tick uncertainty of the free-running prescaler cannot change which class the hold falls into.

// File: rtl/rst_dist_pkg.sv
package rst_dist_pkg;
  localparam int N_REQ   = 3;
  localparam int REQ_PCIE = 0;
  localparam int REQ_USB  = 1;
  localparam int REQ_ETH  = 2;

  typedef enum logic [1:0] {
    HOLD_NONE = 2'd0,
    HOLD_SOFT = 2'd1,
    HOLD_POR  = 2'd2
  } hold_cls_t;
endpackage

// File: rtl/rst_dist_sync.sv
module rst_dist_sync #(
  parameter int WIDTH   = 1,
  parameter int STAGES  = 2,
  parameter logic [WIDTH-1:0] INIT = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stage [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) stage[s] <= INIT;
          else     stage[s] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) stage[s] <= INIT;
          else     stage[s] <= stage[s-1];
        end
      end
    end
  endgenerate

  assign q = stage[STAGES-1];
endmodule

// File: rtl/rst_dist_tick.sv
module rst_dist_tick #(
  parameter int DIV = 1000
) (
  input  logic clk,
  input  logic rst,
  output logic tick
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else if (cnt == LAST) begin
      cnt  <= '0;
      tick <= 1'b1;
    end else begin
      cnt  <= cnt + 1'b1;
      tick <= 1'b0;
    end
  end
endmodule

// File: rtl/rst_dist_hold.sv
module rst_dist_hold
  import rst_dist_pkg::*;
#(
  parameter int SHORT_TICKS = 1000,
  parameter int LONG_TICKS  = 3000
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic pressed,
  input  logic ready,
  output logic soft_fire,
  output logic por_fire
);
  localparam int HW = $clog2(LONG_TICKS + 1);
  localparam logic [HW-1:0] SAT   = HW'(LONG_TICKS);
  localparam logic [HW-1:0] SHORT = HW'(SHORT_TICKS);

  logic [HW-1:0] held;
  logic          pressed_q;
  logic          release_ev;
  hold_cls_t     cls;

  assign release_ev = pressed_q && !pressed;

  always_comb begin
    if (held >= SAT)        cls = HOLD_POR;
    else if (held >= SHORT) cls = HOLD_SOFT;
    else                    cls = HOLD_NONE;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      held      <= '0;
      pressed_q <= 1'b0;
      soft_fire <= 1'b0;
      por_fire  <= 1'b0;
    end else begin
      pressed_q <= pressed;
      soft_fire <= 1'b0;
      por_fire  <= 1'b0;
      if (!pressed) begin
        held <= '0;
      end else if (tick && held != SAT) begin
        held <= held + 1'b1;
      end
      if (release_ev && ready) begin
        soft_fire <= (cls == HOLD_SOFT);
        por_fire  <= (cls == HOLD_POR);
      end
    end
  end
endmodule

// File: rtl/rst_dist_pulse.sv
module rst_dist_pulse #(
  parameter int LEN = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic fire,
  output logic active
);
  localparam int PW = $clog2(LEN + 1);

  logic [PW-1:0] remain;

  always_ff @(posedge clk) begin
    if (rst)                remain <= '0;
    else if (fire)          remain <= PW'(LEN);
    else if (remain != '0)  remain <= remain - 1'b1;
  end

  assign active = (remain != '0);
endmodule

// File: rtl/rst_dist_ctrl.sv
module rst_dist_ctrl
  import rst_dist_pkg::*;
#(
  parameter int CLK_HZ       = 24_000_000,
  parameter int TICK_HZ      = 1000,
  parameter int SHORT_MS     = 1000,
  parameter int LONG_MS      = 3000,
  parameter int PULSE_CYCLES = 16,
  parameter int SYNC_STAGES  = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             btn_n,
  input  logic             pwr_ready,
  input  logic             rst_ready,
  input  logic [N_REQ-1:0] sw_rst_req,
  output logic             ps_srst_n,
  output logic             ps_por_n,
  output logic             pcie_rst_n,
  output logic             usb_phy_rst_n,
  output logic             usb_hub_rst_n,
  output logic             eth_rst_n,
  output logic             pll_rst_n,
  output logic             i2c_rst_n,
  output logic             fan_en,
  output logic             dp_en
);
  localparam int TICK_DIV    = CLK_HZ / TICK_HZ;
  localparam int SHORT_TICKS = SHORT_MS * TICK_HZ / 1000;
  localparam int LONG_TICKS  = LONG_MS * TICK_HZ / 1000;
  localparam int SW          = N_REQ + 3;

  logic [SW-1:0]    raw_in, syn_in;
  logic             btn_s, pwr_s, rdy_s;
  logic [N_REQ-1:0] req_s;
  logic             tick;
  logic             soft_fire, por_fire;
  logic             soft_act, por_act;
  logic [N_REQ-1:0] periph_hold;

  assign raw_in = {btn_n, rst_ready, pwr_ready, sw_rst_req};

  rst_dist_sync #(
    .WIDTH  (SW),
    .STAGES (SYNC_STAGES),
    .INIT   ({1'b1, {(SW-1){1'b0}}})
  ) i_sync (
    .clk (clk),
    .rst (rst),
    .d   (raw_in),
    .q   (syn_in)
  );

  assign btn_s = syn_in[SW-1];
  assign rdy_s = syn_in[SW-2];
  assign pwr_s = syn_in[SW-3];
  assign req_s = syn_in[N_REQ-1:0];

  rst_dist_tick #(.DIV(TICK_DIV)) i_tick (
    .clk  (clk),
    .rst  (rst),
    .tick (tick)
  );

  rst_dist_hold #(
    .SHORT_TICKS (SHORT_TICKS),
    .LONG_TICKS  (LONG_TICKS)
  ) i_hold (
    .clk       (clk),
    .rst       (rst),
    .tick      (tick),
    .pressed   (!btn_s),
    .ready     (rdy_s),
    .soft_fire (soft_fire),
    .por_fire  (por_fire)
  );

  rst_dist_pulse #(.LEN(PULSE_CYCLES)) i_soft_pulse (
    .clk    (clk),
    .rst    (rst),
    .fire   (soft_fire),
    .active (soft_act)
  );

  rst_dist_pulse #(.LEN(PULSE_CYCLES)) i_por_pulse (
    .clk    (clk),
    .rst    (rst),
    .fire   (por_fire),
    .active (por_act)
  );

  generate
    for (genvar p = 0; p < N_REQ; p++) begin : g_periph
      assign periph_hold[p] = !pwr_s || req_s[p];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      ps_srst_n     <= 1'b0;
      ps_por_n      <= 1'b0;
      pcie_rst_n    <= 1'b0;
      usb_phy_rst_n <= 1'b0;
      usb_hub_rst_n <= 1'b0;
      eth_rst_n     <= 1'b0;
      pll_rst_n     <= 1'b0;
      i2c_rst_n     <= 1'b0;
      fan_en        <= 1'b0;
      dp_en         <= 1'b0;
    end else begin
      ps_srst_n     <= !soft_act;
      ps_por_n      <= !por_act;
      pcie_rst_n    <= !periph_hold[REQ_PCIE];
      usb_phy_rst_n <= !periph_hold[REQ_USB];
      usb_hub_rst_n <= !periph_hold[REQ_USB];
      eth_rst_n     <= !periph_hold[REQ_ETH];
      pll_rst_n     <= pwr_s;
      i2c_rst_n     <= pwr_s;
      fan_en        <= pwr_s;
      dp_en         <= pwr_s;
    end
  end
endmodule

// File: rtl/rst_dist_chk.sv
module rst_dist_chk #(
  parameter int PULSE_CYCLES = 16
) (
  input logic       clk,
  input logic       rst,
  input logic       pwr_ready,
  input logic [2:0] sw_rst_req,
  input logic       ps_srst_n,
  input logic       ps_por_n,
  input logic       pcie_rst_n,
  input logic       usb_phy_rst_n,
  input logic       usb_hub_rst_n,
  input logic       eth_rst_n,
  input logic       pll_rst_n,
  input logic       i2c_rst_n,
  input logic       fan_en,
  input logic       dp_en
);
  logic [2:0] since_rst;
  int         srst_low, por_low;
  logic       settled;

  assign settled = (since_rst >= 3'd3);

  always_ff @(posedge clk) begin
    if (rst) begin
      since_rst <= '0;
      srst_low  <= 0;
      por_low   <= 0;
    end else begin
      if (since_rst != 3'd4) since_rst <= since_rst + 1'b1;
      srst_low <= ps_srst_n ? 0 : srst_low + 1;
      por_low  <= ps_por_n  ? 0 : por_low + 1;
    end
  end

  a_r1_outputs_low_in_reset: assert property (@(posedge clk)
    rst |=> !ps_srst_n && !ps_por_n && !pcie_rst_n && !usb_phy_rst_n &&
            !usb_hub_rst_n && !eth_rst_n && !pll_rst_n && !i2c_rst_n &&
            !fan_en && !dp_en);

  a_r3_srst_width: assert property (@(posedge clk) disable iff (rst)
    settled && $rose(ps_srst_n) |-> srst_low == PULSE_CYCLES);

  a_r4_por_width: assert property (@(posedge clk) disable iff (rst)
    settled && $rose(ps_por_n) |-> por_low == PULSE_CYCLES);

  a_r6_pcie_level: assert property (@(posedge clk) disable iff (rst)
    settled |-> pcie_rst_n == ($past(pwr_ready, 3) && !$past(sw_rst_req[0], 3)));

  a_r7_usb_level: assert property (@(posedge clk) disable iff (rst)
    settled |-> usb_phy_rst_n == ($past(pwr_ready, 3) && !$past(sw_rst_req[1], 3))
                && usb_hub_rst_n == usb_phy_rst_n);

  a_r8_eth_level: assert property (@(posedge clk) disable iff (rst)
    settled |-> eth_rst_n == ($past(pwr_ready, 3) && !$past(sw_rst_req[2], 3)));

  a_r9_power_only: assert property (@(posedge clk) disable iff (rst)
    settled |-> pll_rst_n == $past(pwr_ready, 3) && i2c_rst_n == pll_rst_n &&
                fan_en == pll_rst_n && dp_en == pll_rst_n);
endmodule

bind rst_dist_ctrl rst_dist_chk #(.PULSE_CYCLES(PULSE_CYCLES)) i_rst_dist_chk (
  .clk           (clk),
  .rst           (rst),
  .pwr_ready     (pwr_ready),
  .sw_rst_req    (sw_rst_req),
  .ps_srst_n     (ps_srst_n),
  .ps_por_n      (ps_por_n),
  .pcie_rst_n    (pcie_rst_n),
  .usb_phy_rst_n (usb_phy_rst_n),
  .usb_hub_rst_n (usb_hub_rst_n),
  .eth_rst_n     (eth_rst_n),
  .pll_rst_n     (pll_rst_n),
  .i2c_rst_n     (i2c_rst_n),
  .fan_en        (fan_en),
  .dp_en         (dp_en)
);

// File: tb/test_rst_dist_ctrl.sv
`timescale 1ns/1ps
module test_rst_dist_ctrl;
  localparam time CLK_PERIOD = 10ns;
  localparam int  CLK_HZ  = 10000;
  localparam int  TICK_HZ = 1000;   // one tick every 10 cycles
  localparam int  SHORT_MS = 5;     // 50 cycles
  localparam int  LONG_MS  = 15;    // 150 cycles
  localparam int  PULSE    = 8;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       btn_n = 1'b1;
  logic       pwr_ready = 1'b0;
  logic       rst_ready = 1'b1;
  logic [2:0] sw_rst_req = 3'b000;
  logic ps_srst_n, ps_por_n, pcie_rst_n, usb_phy_rst_n, usb_hub_rst_n;
  logic eth_rst_n, pll_rst_n, i2c_rst_n, fan_en, dp_en;

  int n_checks = 0;
  int n_errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rst_dist_ctrl #(
    .CLK_HZ(CLK_HZ), .TICK_HZ(TICK_HZ), .SHORT_MS(SHORT_MS),
    .LONG_MS(LONG_MS), .PULSE_CYCLES(PULSE)
  ) i_rst_dist_ctrl (
    .clk(clk), .rst(rst), .btn_n(btn_n), .pwr_ready(pwr_ready),
    .rst_ready(rst_ready), .sw_rst_req(sw_rst_req),
    .ps_srst_n(ps_srst_n), .ps_por_n(ps_por_n), .pcie_rst_n(pcie_rst_n),
    .usb_phy_rst_n(usb_phy_rst_n), .usb_hub_rst_n(usb_hub_rst_n),
    .eth_rst_n(eth_rst_n), .pll_rst_n(pll_rst_n), .i2c_rst_n(i2c_rst_n),
    .fan_en(fan_en), .dp_en(dp_en)
  );

  task automatic check(input string req, input int actual, input int expected);
    n_checks++;
    if (actual != expected) begin
      n_errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, actual, expected);
    end
  endtask

  // Hold the button for hold_cyc cycles, then watch for 60 cycles.
  task automatic press(input int hold_cyc, output int srst_lo, output int por_lo,
                       output int lo_while_held);
    srst_lo = 0; por_lo = 0; lo_while_held = 0;
    @(negedge clk) btn_n = 1'b0;
    for (int i = 0; i < hold_cyc; i++) begin
      @(negedge clk);
      if (!ps_srst_n || !ps_por_n) lo_while_held++;
    end
    btn_n = 1'b1;
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      if (!ps_srst_n) srst_lo++;
      if (!ps_por_n)  por_lo++;
    end
  endtask

  task automatic set_levels(input logic pwr, input logic [2:0] req);
    @(negedge clk);
    pwr_ready = pwr; sw_rst_req = req;
    repeat (4) @(negedge clk);
  endtask

  task automatic check_levels(input string tag, input logic pwr, input logic [2:0] req);
    check({tag, " R6 pcie"}, pcie_rst_n, pwr && !req[0]);
    check({tag, " R7 usb phy"}, usb_phy_rst_n, pwr && !req[1]);
    check({tag, " R7 usb hub"}, usb_hub_rst_n, pwr && !req[1]);
    check({tag, " R8 eth"}, eth_rst_n, pwr && !req[2]);
    check({tag, " R9 pll"}, pll_rst_n, pwr);
    check({tag, " R9 i2c"}, i2c_rst_n, pwr);
    check({tag, " R9 fan"}, fan_en, pwr);
    check({tag, " R9 dp"}, dp_en, pwr);
  endtask

  task automatic t_reset_state();
    repeat (3) @(negedge clk);
    check("R1 srst", ps_srst_n, 0);   check("R1 por", ps_por_n, 0);
    check("R1 pcie", pcie_rst_n, 0);  check("R1 usb", usb_phy_rst_n, 0);
    check("R1 eth", eth_rst_n, 0);    check("R1 pll", pll_rst_n, 0);
    check("R1 fan", fan_en, 0);       check("R1 dp", dp_en, 0);
  endtask

  task automatic t_short_noise();
    int s, p, h;
    press(20, s, p, h);
    check("R2 srst", s, 0); check("R2 por", p, 0);
  endtask

  task automatic t_soft();
    int s, p, h;
    press(100, s, p, h);
    check("R3 srst width", s, PULSE); check("R3 por", p, 0);
  endtask

  task automatic t_long();
    int s, p, h;
    press(300, s, p, h);
    check("R4 por width", p, PULSE); check("R4 srst", s, 0);
  endtask

  task automatic t_not_ready();
    int s, p, h;
    @(negedge clk) rst_ready = 1'b0;
    press(100, s, p, h);
    check("R5 soft srst", s, 0); check("R5 soft por", p, 0);
    press(300, s, p, h);
    check("R5 long srst", s, 0); check("R5 long por", p, 0);
    @(negedge clk) rst_ready = 1'b1;
  endtask

  task automatic t_very_long();
    int s, p, h;
    press(1000, s, p, h);
    check("R11 held", h, 0); check("R11 por once", p, PULSE);
    check("R11 srst", s, 0);
  endtask

  task automatic t_latency();
    int seen;
    @(negedge clk) sw_rst_req = 3'b001;
    @(negedge clk); check("R10 +1", pcie_rst_n, 1);
    @(negedge clk); check("R10 +2", pcie_rst_n, 1);
    @(negedge clk); check("R10 +3", pcie_rst_n, 0);
    seen = pcie_rst_n;
    sw_rst_req = 3'b000;
    repeat (4) @(negedge clk);
    check("R10 release", pcie_rst_n, 1);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    t_reset_state();
    rst = 1'b0;
    set_levels(1'b0, 3'b000); check_levels("pwr off", 1'b0, 3'b000);
    set_levels(1'b0, 3'b111); check_levels("pwr off req", 1'b0, 3'b111);
    set_levels(1'b1, 3'b000); check_levels("pwr on", 1'b1, 3'b000);
    set_levels(1'b1, 3'b001); check_levels("pcie req", 1'b1, 3'b001);
    set_levels(1'b1, 3'b010); check_levels("usb req", 1'b1, 3'b010);
    set_levels(1'b1, 3'b100); check_levels("eth req", 1'b1, 3'b100);
    set_levels(1'b1, 3'b000);
    t_latency();
    t_short_noise();
    t_soft();
    t_long();
    t_not_ready();
    t_very_long();
    t_soft();
    done = 1'b1;
    $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_checks++; n_errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end
endmodule